// File: doc/BRIEF.md
# Tri-Color LED Hue-Fade and Mode Controller

This block drives two tri-color LEDs, each through three pulse-width-modulated channels. Out of reset both LEDs run a continuous cross-fade. Red hands over to green, green hands over to blue, and blue hands back to red. At every step one channel drops by one count while the next one rises by one, so the three duty values always add up to the full-scale value. A prescaler sets the pace of the steps.

Single-cycle button pulses, already debounced upstream, change what the LEDs show. Three buttons force a fixed red, green or blue on both LEDs. A fourth button, called "down", steps through a ring of modes:
- from a forced color it returns to the joint fade;
- from the joint fade it splits the two LEDs, so LED 0 keeps fading while LED 1 holds the last forced color;
- from the split it turns both LEDs dark;
- from dark it returns to the joint fade.

The six duty values are also presented as two 24-bit words, so that another block can display them.

Top module: `rgb_fade_ctrl`

## Requirements
- R1: While reset is held and after it is released, the block is in joint-fade mode. Both LEDs start at duty red=255, green=0, blue=0, and until a button is pressed both duty words carry the same fader value.
- R2: At each step the fader moves through 765 steps per full loop. In steps 0 to 254 red falls by one and green rises by one. In steps 255 to 509 green falls and blue rises. In steps 510 to 764 blue falls and red rises. The sum of red, green and blue is always 255.
- R3: The fader takes one step every STEP_DIV clock cycles. The first step happens on the STEP_DIV-th rising edge after reset is released.
- R4: A left pulse forces both LEDs to solid red (FF0000). A center pulse forces both to solid green (00FF00). A right pulse forces both to solid blue (0000FF). The change is visible after the clock edge that samples the pulse.
- R5: A down pulse while a forced color is shown returns both LEDs to the fade loop.
- R6: A down pulse during the joint fade enters split mode. In split mode LED 0 shows the fader and LED 1 holds the last forced color, which is red if no color has been forced since reset.
- R7: A down pulse in split mode turns both LEDs off. All six duty values read 0 and all six PWM outputs stay low.
- R8: A down pulse while the LEDs are off returns them to the joint fade.
- R9: When several button pulses arrive in the same cycle, down wins over left, left wins over center, and center wins over right.
- R10: All six channels share one 8-bit PWM counter. The counter is 0 during reset and rises by one on every clock edge, wrapping after 255. A channel output is high exactly while the counter is less than that channel's duty value, so over any 256 consecutive cycles it is high for a number of cycles equal to the duty.
- R11: Each duty word carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each 3-bit PWM output carries red in bit 2, green in bit 1 and blue in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_left | input | 1 | Single-cycle pulse: force red |
| btn_center | input | 1 | Single-cycle pulse: force green |
| btn_right | input | 1 | Single-cycle pulse: force blue |
| btn_down | input | 1 | Single-cycle pulse: step the mode ring |
| led0_pwm | output | 3 | PWM drive of LED 0, {red, green, blue} |
| led1_pwm | output | 3 | PWM drive of LED 1, {red, green, blue} |
| duty0 | output | 24 | Current duty of LED 0, {red, green, blue} |
| duty1 | output | 24 | Current duty of LED 1, {red, green, blue} |

## Verification
The main instance is built with STEP_DIV=1, so the fader steps on every clock. This brings the whole 765-step loop, including both phase hand-overs and the wrap back to red, within reach of a cycle-by-cycle sweep of under a thousand cycles. Every duty value and every PWM bit is compared against arithmetic on the cycle count. A second instance is built with STEP_DIV=3 to exercise the prescaler branch, where each fader value must hold for exactly three cycles. The mode ring, the held split color and the button priority are checked on the STEP_DIV=1 instance, using combinations of simultaneous button pulses.

// File: rtl/rgb_fade_pkg.sv
package rgb_fade_pkg;

   parameter int unsigned RGB_DW = 8;

   localparam logic [RGB_DW-1:0] RGB_MAX = '1;
   localparam logic [RGB_DW-1:0] RGB_ZERO = '0;

   typedef struct packed {
      logic [RGB_DW-1:0] r;
      logic [RGB_DW-1:0] g;
      logic [RGB_DW-1:0] b;
   } rgb_t;

   typedef enum logic [1:0] {
      MODE_FADE  = 2'd0,
      MODE_SOLID = 2'd1,
      MODE_SPLIT = 2'd2,
      MODE_OFF   = 2'd3
   } rgb_mode_e;

   typedef enum logic [1:0] {
      PH_RG = 2'd0,
      PH_GB = 2'd1,
      PH_BR = 2'd2
   } fade_phase_e;

   localparam rgb_t COLOR_RED   = '{r: RGB_MAX,  g: RGB_ZERO, b: RGB_ZERO};
   localparam rgb_t COLOR_GREEN = '{r: RGB_ZERO, g: RGB_MAX,  b: RGB_ZERO};
   localparam rgb_t COLOR_BLUE  = '{r: RGB_ZERO, g: RGB_ZERO, b: RGB_MAX};
   localparam rgb_t COLOR_DARK  = '{r: RGB_ZERO, g: RGB_ZERO, b: RGB_ZERO};

endpackage

// File: rtl/rgb_step_tick.sv
module rgb_step_tick #(
   parameter int unsigned DIV = 400000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 1) begin : g_bad_div
      $error("rgb_step_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every_cycle
      assign tick = 1'b1;
   end else begin : g_counted
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign tick = (cnt_q == LAST);

      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end

endmodule

// File: rtl/rgb_hue_fader.sv
module rgb_hue_fader
   import rgb_fade_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output rgb_t color
);

   localparam logic [RGB_DW-1:0] NEAR_TOP = RGB_MAX - 1'b1;

   rgb_t        col_q;
   fade_phase_e ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= COLOR_RED;
         ph_q  <= PH_RG;
      end else if (step) begin
         case (ph_q)
            PH_RG: begin
               col_q.r <= col_q.r - 1'b1;
               col_q.g <= col_q.g + 1'b1;
               if (col_q.g == NEAR_TOP) ph_q <= PH_GB;
            end
            PH_GB: begin
               col_q.g <= col_q.g - 1'b1;
               col_q.b <= col_q.b + 1'b1;
               if (col_q.b == NEAR_TOP) ph_q <= PH_BR;
            end
            PH_BR: begin
               col_q.b <= col_q.b - 1'b1;
               col_q.r <= col_q.r + 1'b1;
               if (col_q.r == NEAR_TOP) ph_q <= PH_RG;
            end
            default: begin
               col_q <= COLOR_RED;
               ph_q  <= PH_RG;
            end
         endcase
      end
   end

   assign color = col_q;

   // R2
   sum_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({2'b00, col_q.r} + {2'b00, col_q.g} + {2'b00, col_q.b}) == {2'b00, RGB_MAX});

   // R3
   hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(col_q));

endmodule

// File: rtl/rgb_pwm_bank.sv
module rgb_pwm_bank #(
   parameter int unsigned N_CH = 6,
   parameter int unsigned DW   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CH*DW-1:0] duty_flat,
   output logic [N_CH-1:0]    pwm
);

   if (DW < 2) begin : g_bad_dw
      $error("rgb_pwm_bank: DW must be at least 2");
   end
   if (N_CH < 1) begin : g_bad_n
      $error("rgb_pwm_bank: N_CH must be at least 1");
   end

   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic [DW-1:0] duty_i;
      assign duty_i = duty_flat[i*DW +: DW];
      assign pwm[i] = (cnt_q < duty_i);

      // R10
      zero_duty_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (duty_i == '0) |-> !pwm[i]);
   end

endmodule

// File: rtl/rgb_fade_ctrl.sv
module rgb_fade_ctrl
   import rgb_fade_pkg::*;
#(
   parameter int unsigned STEP_DIV = 400000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        btn_left,
   input  logic        btn_center,
   input  logic        btn_right,
   input  logic        btn_down,
   output logic [2:0]  led0_pwm,
   output logic [2:0]  led1_pwm,
   output logic [23:0] duty0,
   output logic [23:0] duty1
);

   localparam int unsigned N_LED   = 2;
   localparam int unsigned N_CH    = N_LED * 3;
   localparam int unsigned WORD_W  = 3 * RGB_DW;

   if (WORD_W != 24) begin : g_bad_word
      $error("rgb_fade_ctrl: duty words require 8-bit channels");
   end

   logic      step;
   rgb_t      fade_c;
   rgb_t      solid_q;
   rgb_mode_e mode_q;
   rgb_t      c0, c1;
   logic [N_CH-1:0] pwm_all;

   rgb_step_tick #(.DIV(STEP_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (step)
   );

   rgb_hue_fader u_fader (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .color (fade_c)
   );

   // Down outranks left, left outranks center, center outranks right.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MODE_FADE;
         solid_q <= COLOR_RED;
      end else if (btn_down) begin
         case (mode_q)
            MODE_SOLID: mode_q <= MODE_FADE;
            MODE_FADE:  mode_q <= MODE_SPLIT;
            MODE_SPLIT: mode_q <= MODE_OFF;
            default:    mode_q <= MODE_FADE;
         endcase
      end else if (btn_left) begin
         mode_q  <= MODE_SOLID;
         solid_q <= COLOR_RED;
      end else if (btn_center) begin
         mode_q  <= MODE_SOLID;
         solid_q <= COLOR_GREEN;
      end else if (btn_right) begin
         mode_q  <= MODE_SOLID;
         solid_q <= COLOR_BLUE;
      end
   end

   always_comb begin
      case (mode_q)
         MODE_FADE: begin
            c0 = fade_c;
            c1 = fade_c;
         end
         MODE_SOLID: begin
            c0 = solid_q;
            c1 = solid_q;
         end
         MODE_SPLIT: begin
            c0 = fade_c;
            c1 = solid_q;
         end
         default: begin
            c0 = COLOR_DARK;
            c1 = COLOR_DARK;
         end
      endcase
   end

   rgb_pwm_bank #(.N_CH(N_CH), .DW(RGB_DW)) u_pwm (
      .clk       (clk),
      .rst_n     (rst_n),
      .duty_flat ({c0, c1}),
      .pwm       (pwm_all)
   );

   assign led0_pwm = pwm_all[5:3];
   assign led1_pwm = pwm_all[2:0];
   assign duty0    = c0;
   assign duty1    = c1;

   // R4
   forced_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!btn_down && (btn_left || btn_center || btn_right)) |=> (mode_q == MODE_SOLID && duty0 == duty1));

   // R9
   down_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      btn_down |=> (mode_q != MODE_SOLID));

   // R8
   off_to_fade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (btn_down && mode_q == MODE_OFF) |=> (mode_q == MODE_FADE));

   // R7
   off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF) |-> (led0_pwm == 3'b000 && led1_pwm == 3'b000));

   // R6
   split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SPLIT && !btn_down && !btn_left && !btn_center && !btn_right) |=> $stable(duty1));

endmodule

// File: tb/rgb_fade_ctrl_tb_top.sv
module rgb_fade_ctrl_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic b_left = 1'b0, b_center = 1'b0, b_right = 1'b0, b_down = 1'b0;
   logic [2:0]  led0, led1, led0_s3, led1_s3;
   logic [23:0] d0, d1, d0_s3, d1_s3;

   int n_chk = 0;
   int n_fail = 0;
   int n_edge = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) n_edge <= 0;
      else        n_edge <= n_edge + 1;
   end

   rgb_fade_ctrl #(.STEP_DIV(1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .btn_left(b_left), .btn_center(b_center), .btn_right(b_right), .btn_down(b_down),
      .led0_pwm(led0), .led1_pwm(led1), .duty0(d0), .duty1(d1)
   );

   rgb_fade_ctrl #(.STEP_DIV(3)) dut3_i (
      .clk(clk), .rst_n(rst_n),
      .btn_left(1'b0), .btn_center(1'b0), .btn_right(1'b0), .btn_down(1'b0),
      .led0_pwm(led0_s3), .led1_pwm(led1_s3), .duty0(d0_s3), .duty1(d1_s3)
   );

   function automatic logic [23:0] fade_at(int k);
      int m = k % 765;
      int j;
      logic [7:0] r, g, b;
      if (m < 255) begin
         r = 8'(255 - m); g = 8'(m); b = 8'd0;
      end else if (m < 510) begin
         j = m - 255;
         r = 8'd0; g = 8'(255 - j); b = 8'(j);
      end else begin
         j = m - 510;
         r = 8'(j); g = 8'd0; b = 8'(255 - j);
      end
      return {r, g, b};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, n_edge);
      end
   endtask

   task automatic press(input logic [3:0] dlcr);
      @(negedge clk);
      {b_down, b_left, b_center, b_right} = dlcr;
      @(negedge clk);
      {b_down, b_left, b_center, b_right} = 4'b0000;
   endtask

   task automatic expect_both(input string tag, input logic [23:0] e0, input logic [23:0] e1);
      check(d0 == e0, tag, {8'd0, d0}, {8'd0, e0});
      check(d1 == e1, tag, {8'd0, d1}, {8'd0, e1});
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", n_edge);
      summary();
   end

   initial begin
      int hr, hg, hb;
      logic [23:0] e;
      repeat (3) @(negedge clk);
      // R1 reset state
      expect_both("R1 reset", 24'hFF0000, 24'hFF0000);
      rst_n = 1'b1;

      // R1 R2 R3 R10 fade sweep across all phase boundaries and the wrap
      for (int i = 0; i < 800; i++) begin
         @(negedge clk);
         e = fade_at(n_edge);
         check(d0 == e, "R2 fade led0", {8'd0, d0}, {8'd0, e});
         check(d1 == e, "R1 fade led1", {8'd0, d1}, {8'd0, e});
         check(led0 == {(8'(n_edge % 256) < e[23:16]), (8'(n_edge % 256) < e[15:8]),
                        (8'(n_edge % 256) < e[7:0])},
               "R10 pwm compare", {29'd0, led0},
               {29'd0, (8'(n_edge % 256) < e[23:16]), (8'(n_edge % 256) < e[15:8]),
                (8'(n_edge % 256) < e[7:0])});
         check(d0_s3 == fade_at(n_edge / 3), "R3 prescaled", {8'd0, d0_s3}, {8'd0, fade_at(n_edge / 3)});
      end

      // R6 split with no color forced since reset: LED1 holds red
      press(4'b1000);
      expect_both("R6 split default", fade_at(n_edge), 24'hFF0000);
      @(negedge clk);
      expect_both("R6 split keeps fading", fade_at(n_edge), 24'hFF0000);

      // R7 off
      press(4'b1000);
      expect_both("R7 off duty", 24'h000000, 24'h000000);
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         check({led0, led1} == 6'd0, "R7 off pwm", {26'd0, led0, led1}, 32'd0);
      end

      // R8 off back to fade
      press(4'b1000);
      expect_both("R8 refade", fade_at(n_edge), fade_at(n_edge));

      // R4 R11 forced colors
      press(4'b0001);
      expect_both("R4 R11 blue", 24'h0000FF, 24'h0000FF);
      hr = 0; hg = 0; hb = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         hr += int'(led1[2]); hg += int'(led1[1]); hb += int'(led1[0]);
      end
      check(hr == 0 && hg == 0 && hb == 255, "R10 R11 blue duty count",
            32'(hr * 65536 + hg * 256 + hb), 32'(255));
      press(4'b0010);
      expect_both("R4 green", 24'h00FF00, 24'h00FF00);
      press(4'b0100);
      expect_both("R4 red", 24'hFF0000, 24'hFF0000);

      // R5 solid to fade
      press(4'b1000);
      expect_both("R5 solid to fade", fade_at(n_edge), fade_at(n_edge));

      // R6 split holds last forced color
      press(4'b0010);
      press(4'b1000);
      press(4'b1000);
      expect_both("R6 split green", fade_at(n_edge), 24'h00FF00);
      hr = 0; hg = 0; hb = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         hr += int'(led1[2]); hg += int'(led1[1]); hb += int'(led1[0]);
      end
      check(hr == 0 && hg == 255 && hb == 0, "R10 split green count",
            32'(hr * 65536 + hg * 256 + hb), 32'(255 * 256));

      // R9 priority
      press(4'b1100);
      expect_both("R9 down over left", 24'h000000, 24'h000000);
      press(4'b0110);
      expect_both("R9 left over center", 24'hFF0000, 24'hFF0000);
      press(4'b0011);
      expect_both("R9 center over right", 24'h00FF00, 24'h00FF00);
      press(4'b1011);
      expect_both("R9 down over colors", fade_at(n_edge), fade_at(n_edge));

      summary();
   end

endmodule